// File: doc/BRIEF.md
# Four-Phase Handshake Transfer Controller

This block moves data words over a clockless request/acknowledge link. It has two engines. The sending engine takes words from local logic and drives them onto an outgoing link. The receiving engine takes words from an incoming link and hands them to local logic. Both engines speak the same handshake flavour, chosen by a mode input.

In source-initiated mode the sender puts a word out, raises its valid line and waits for the far end to accept. In destination-initiated mode the receiver advertises that it is ready, and the sender only drives a word after seeing that ready. Every step waits on the peer for as long as the peer needs, so the slower side sets the pace. A programmable watchdog limit lets each engine give up on a peer that has gone silent.

Each incoming handshake line passes through a synchronizer before any state machine acts on it. The data lines are not synchronized: they are sampled only once the synchronized valid line shows they are settled. The active mode is latched only while both engines are at rest.

Top module: `hs_xfer_ctrl`

## Requirements
- R1: After reset the outgoing valid is low, the incoming-side acknowledge is low, the sender reports ready, no received-word pulse is present, and both error flags are clear. The active mode resets to source-initiated.
- R2: With `mode_i` = 0 (source-initiated), the sender behaves as follows:
  - it drives the word before raising `lnk_tx_dv_o`;
  - it holds `lnk_tx_dv_o` high until `lnk_tx_ack_i` is seen high;
  - it reports ready again only after `lnk_tx_ack_i` is seen low.
- R3: With `mode_i` = 1 (destination-initiated), the sender keeps `lnk_tx_dv_o` low until `lnk_tx_ack_i` (the peer's ready) is seen high. It then keeps `lnk_tx_dv_o` high until that ready is seen low.
- R4: In source-initiated mode, a rising `lnk_rx_dv_i` makes the receiver do three things: capture `lnk_rx_data_i`, pulse `rx_valid_o` for exactly one cycle with that word on `rx_data_o`, and raise `lnk_rx_ack_o`. The receiver drops `lnk_rx_ack_o` only after `lnk_rx_dv_i` is seen low, and captures each valid pulse exactly once.
- R5: In destination-initiated mode the receiver holds `lnk_rx_ack_o` high at rest as its ready. A rising `lnk_rx_dv_i` causes a single capture and drops the ready. The ready is raised again only after `lnk_rx_dv_i` is seen low.
- R6: The outgoing word on `lnk_tx_data_o` is stable from at least one cycle before `lnk_tx_dv_o` rises until at least one cycle after it falls.
- R7: An engine waiting on a peer response after its own move may go `tmo_limit_i` consecutive cycles with no edge on its synchronized handshake input. When that happens it returns to rest with its link output low and sets its error flag (`tx_err_o` or `rx_err_o`). The flag stays set until reset.
- R8: With `tmo_limit_i` = 0 no timeout occurs, and an engine waits indefinitely.
- R9: A change of `mode_i` takes effect only while the sender is idle and the receiver is at rest. A change during a transfer is ignored until that point.
- R10: A handshake input edge influences the outputs through a two-stage synchronizer. In source-initiated mode, `lnk_tx_dv_o` falls on the third rising clock edge after `lnk_tx_ack_i` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | Handshake flavour: 0 source-initiated, 1 destination-initiated |
| tmo_limit_i | input | TMO_W | Silent-peer limit in cycles, 0 disables |
| tx_valid_i | input | 1 | Local word offered to the sender |
| tx_data_i | input | DW | Local word to send |
| tx_ready_o | output | 1 | Sender idle and taking a word |
| tx_err_o | output | 1 | Sticky sender timeout flag |
| lnk_tx_data_o | output | DW | Outgoing link data |
| lnk_tx_dv_o | output | 1 | Outgoing link data valid |
| lnk_tx_ack_i | input | 1 | Peer accept (source-initiated) or ready (destination-initiated), asynchronous |
| lnk_rx_data_i | input | DW | Incoming link data |
| lnk_rx_dv_i | input | 1 | Incoming link data valid, asynchronous |
| lnk_rx_ack_o | output | 1 | Accept (source-initiated) or ready (destination-initiated) to the peer |
| rx_valid_o | output | 1 | One-cycle pulse per received word |
| rx_data_o | output | DW | Received word |
| rx_err_o | output | 1 | Sticky receiver timeout flag |

## Verification
The bench builds the block with DW = 12, TMO_W = 8 and two synchronizer stages. The narrow limit field keeps a silent-peer expiry to a few dozen cycles, so both sticky flags can be driven within a short run. It also makes a 200-cycle idle wait with the limit at zero long enough to show that nothing fires. With two stages, the three-edge response from acknowledge to valid fall can be checked cycle by cycle. In a loopback arrangement, the sender's link outputs feed the receiver's inputs, so whole words cross in each mode. The bench also drives each link side directly to hold the peer still, reorder steps, or switch mode in the middle of a transfer.

// File: rtl/hs_pkg.sv
package hs_pkg;

  typedef enum logic {
    HS_SRC_INIT = 1'b0,
    HS_DST_INIT = 1'b1
  } hs_mode_e;

  typedef enum logic [2:0] {
    TX_IDLE,
    TX_WAIT_RDY,
    TX_SETUP,
    TX_ASSERT,
    TX_RELEASE
  } tx_state_e;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_ACK,
    RX_DRAIN
  } rx_state_e;

  // any change of a synchronized handshake line
  function automatic logic line_toggled(input logic now_v, input logic prev_v);
    return now_v ^ prev_v;
  endfunction

  // rising change of a synchronized handshake line
  function automatic logic line_rose(input logic now_v, input logic prev_v);
    return now_v & ~prev_v;
  endfunction

endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/hs_timeout.sv
module hs_timeout #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_i,
  input  logic         kick_i,
  input  logic [W-1:0] limit_i,
  output logic         expire_o,
  output logic         err_o
);

  logic [W-1:0] cnt_q;
  logic         err_q;

  // limit of zero never hits; a lowered limit still hits at once
  function automatic logic limit_hit(input logic [W-1:0] cnt, input logic [W-1:0] lim);
    return (lim != '0) && (cnt >= lim - 1'b1);
  endfunction

  assign expire_o = run_i && !kick_i && limit_hit(cnt_q, limit_i);
  assign err_o    = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (!run_i || kick_i)  cnt_q <= '0;
      else if (!expire_o)    cnt_q <= cnt_q + 1'b1;
      if (expire_o)          err_q <= 1'b1;
    end
  end

  // R7
  tmo_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> err_o);

  // R7
  tmo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);

endmodule

// File: rtl/hs_src_engine.sv
module hs_src_engine import hs_pkg::*; #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  hs_mode_e      mode_i,
  input  logic          word_valid_i,
  input  logic [DW-1:0] word_i,
  output logic          word_ready_o,
  output logic          dv_o,
  output logic [DW-1:0] data_o,
  input  logic          ack_s_i,
  input  logic          expire_i,
  output logic          timed_o,
  output logic          idle_o
);

  tx_state_e     state_q, state_d;
  logic [DW-1:0] data_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      TX_IDLE:
        if (word_valid_i)
          state_d = (mode_i == HS_SRC_INIT) ? TX_SETUP : TX_WAIT_RDY;
      TX_WAIT_RDY:
        if (ack_s_i) state_d = TX_SETUP;
      TX_SETUP:
        state_d = TX_ASSERT;
      TX_ASSERT:
        if (expire_i)                                   state_d = TX_IDLE;
        else if (mode_i == HS_SRC_INIT && ack_s_i)      state_d = TX_RELEASE;
        else if (mode_i == HS_DST_INIT && !ack_s_i)     state_d = TX_IDLE;
      TX_RELEASE:
        if (expire_i || !ack_s_i) state_d = TX_IDLE;
      default:
        state_d = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == TX_IDLE && word_valid_i) data_q <= word_i;
    end
  end

  assign word_ready_o = (state_q == TX_IDLE);
  assign idle_o       = (state_q == TX_IDLE);
  assign dv_o         = (state_q == TX_ASSERT);
  assign data_o       = data_q;
  assign timed_o      = (state_q == TX_ASSERT) || (state_q == TX_RELEASE);

  // R6
  tx_data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dv_o || $past(dv_o)) |-> $stable(data_o));

  // R2
  tx_src_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dv_o) && !$past(expire_i) && $past(mode_i) == HS_SRC_INIT) |-> $past(ack_s_i));

  // R3
  tx_dst_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dv_o) && !$past(expire_i) && $past(mode_i) == HS_DST_INIT) |-> !$past(ack_s_i));

  // R3
  tx_dst_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dv_o) && $past(mode_i) == HS_DST_INIT) |-> $past(ack_s_i, 2));

  // R7
  tx_tmo_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire_i |=> (word_ready_o && !dv_o));

endmodule

// File: rtl/hs_dst_engine.sv
module hs_dst_engine import hs_pkg::*; #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  hs_mode_e      mode_i,
  input  hs_mode_e      cur_mode_i,
  input  logic          dv_s_i,
  input  logic          dv_rise_i,
  input  logic [DW-1:0] data_i,
  output logic          ack_o,
  output logic          word_valid_o,
  output logic [DW-1:0] word_o,
  input  logic          expire_i,
  output logic          timed_o,
  output logic          rest_o
);

  rx_state_e     state_q, state_d;
  logic          take;
  logic          valid_q;
  logic [DW-1:0] word_q;

  always_comb begin
    state_d = state_q;
    take    = 1'b0;
    unique case (state_q)
      RX_IDLE:
        if (mode_i == HS_DST_INIT) state_d = RX_ACK;
        else if (dv_rise_i) begin
          take    = 1'b1;
          state_d = RX_ACK;
        end
      RX_ACK:
        if (mode_i == HS_SRC_INIT) begin
          if (expire_i || !dv_s_i) state_d = RX_IDLE;
        end else if (dv_rise_i) begin
          take    = 1'b1;
          state_d = RX_DRAIN;
        end
      RX_DRAIN:
        if (expire_i || !dv_s_i) state_d = RX_IDLE;
      default:
        state_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      valid_q <= 1'b0;
      word_q  <= '0;
    end else begin
      state_q <= state_d;
      valid_q <= take;
      if (take) word_q <= data_i;
    end
  end

  assign ack_o        = (state_q == RX_ACK);
  assign word_valid_o = valid_q;
  assign word_o       = word_q;
  assign timed_o      = (state_q == RX_DRAIN) ||
                        (state_q == RX_ACK && mode_i == HS_SRC_INIT);
  assign rest_o       = !dv_s_i && ((state_q == RX_IDLE) ||
                        (state_q == RX_ACK && cur_mode_i == HS_DST_INIT));

  // R4
  rx_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |-> $past(dv_s_i));

  // R4
  rx_src_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ack_o) && $past(mode_i) == HS_SRC_INIT && !$past(expire_i)) |-> !$past(dv_s_i));

  // R5
  rx_dst_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ack_o) && $past(mode_i) == HS_DST_INIT && !$past(expire_i)) |-> word_valid_o);

  // R4
  rx_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |=> !word_valid_o);

endmodule

// File: rtl/hs_xfer_ctrl.sv
module hs_xfer_ctrl import hs_pkg::*; #(
  parameter int DW          = 16,
  parameter int TMO_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_i,
  input  logic [TMO_W-1:0] tmo_limit_i,
  input  logic             tx_valid_i,
  input  logic [DW-1:0]    tx_data_i,
  output logic             tx_ready_o,
  output logic             tx_err_o,
  output logic [DW-1:0]    lnk_tx_data_o,
  output logic             lnk_tx_dv_o,
  input  logic             lnk_tx_ack_i,
  input  logic [DW-1:0]    lnk_rx_data_i,
  input  logic             lnk_rx_dv_i,
  output logic             lnk_rx_ack_o,
  output logic             rx_valid_o,
  output logic [DW-1:0]    rx_data_o,
  output logic             rx_err_o
);

  logic     ack_s, ack_s_q, dv_s, dv_s_q;
  logic     tx_kick, rx_kick, rx_rise;
  logic     tx_timed, rx_timed, tx_expire, rx_expire;
  logic     tx_idle, rx_rest, quiet;
  hs_mode_e mode_q, mode_eff;

  hs_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(clk), .rst_n(rst_n), .d_i(lnk_tx_ack_i), .q_o(ack_s));

  hs_sync #(.STAGES(SYNC_STAGES)) u_dv_sync (
    .clk(clk), .rst_n(rst_n), .d_i(lnk_rx_dv_i), .q_o(dv_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_s_q <= 1'b0;
      dv_s_q  <= 1'b0;
      mode_q  <= HS_SRC_INIT;
    end else begin
      ack_s_q <= ack_s;
      dv_s_q  <= dv_s;
      mode_q  <= mode_eff;
    end
  end

  assign tx_kick  = line_toggled(ack_s, ack_s_q);
  assign rx_kick  = line_toggled(dv_s, dv_s_q);
  assign rx_rise  = line_rose(dv_s, dv_s_q);
  assign quiet    = tx_idle && rx_rest;
  assign mode_eff = quiet ? hs_mode_e'(mode_i) : mode_q;

  hs_timeout #(.W(TMO_W)) u_tx_tmo (
    .clk(clk), .rst_n(rst_n), .run_i(tx_timed), .kick_i(tx_kick),
    .limit_i(tmo_limit_i), .expire_o(tx_expire), .err_o(tx_err_o));

  hs_timeout #(.W(TMO_W)) u_rx_tmo (
    .clk(clk), .rst_n(rst_n), .run_i(rx_timed), .kick_i(rx_kick),
    .limit_i(tmo_limit_i), .expire_o(rx_expire), .err_o(rx_err_o));

  hs_src_engine #(.DW(DW)) u_src (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_eff),
    .word_valid_i(tx_valid_i), .word_i(tx_data_i), .word_ready_o(tx_ready_o),
    .dv_o(lnk_tx_dv_o), .data_o(lnk_tx_data_o), .ack_s_i(ack_s),
    .expire_i(tx_expire), .timed_o(tx_timed), .idle_o(tx_idle));

  hs_dst_engine #(.DW(DW)) u_dst (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_eff), .cur_mode_i(mode_q),
    .dv_s_i(dv_s), .dv_rise_i(rx_rise), .data_i(lnk_rx_data_i),
    .ack_o(lnk_rx_ack_o), .word_valid_o(rx_valid_o), .word_o(rx_data_o),
    .expire_i(rx_expire), .timed_o(rx_timed), .rest_o(rx_rest));

  // R9
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_q) |-> $past(quiet));

  // R7
  tx_err_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_expire |=> tx_err_o);

endmodule

// File: tb/test_hs_xfer_ctrl.sv
`timescale 1ns/1ps
module test_hs_xfer_ctrl;

  localparam int DW    = 12;
  localparam int TMO_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             mode = 1'b0;
  logic [TMO_W-1:0] limit = '0;
  logic             tx_valid = 1'b0;
  logic [DW-1:0]    tx_data = '0;
  logic             tx_ready, tx_err, tx_dv, rx_ack, rx_valid, rx_err;
  logic [DW-1:0]    tx_lnk_data, rx_data;
  logic             loop = 1'b0;
  logic             man_ack = 1'b0, man_dv = 1'b0;
  logic [DW-1:0]    man_data = '0;
  logic             ack_in, dv_in;
  logic [DW-1:0]    data_in;

  int n_chk = 0, n_fail = 0, rx_cnt = 0;
  logic [DW-1:0] rx_buf [0:7];
  bit done = 0;

  always #2.5 clk = ~clk;

  assign ack_in  = loop ? rx_ack      : man_ack;
  assign dv_in   = loop ? tx_dv       : man_dv;
  assign data_in = loop ? tx_lnk_data : man_data;

  hs_xfer_ctrl #(.DW(DW), .TMO_W(TMO_W), .SYNC_STAGES(2)) i_hs_xfer_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .tmo_limit_i(limit),
    .tx_valid_i(tx_valid), .tx_data_i(tx_data), .tx_ready_o(tx_ready),
    .tx_err_o(tx_err), .lnk_tx_data_o(tx_lnk_data), .lnk_tx_dv_o(tx_dv),
    .lnk_tx_ack_i(ack_in), .lnk_rx_data_i(data_in), .lnk_rx_dv_i(dv_in),
    .lnk_rx_ack_o(rx_ack), .rx_valid_o(rx_valid), .rx_data_o(rx_data),
    .rx_err_o(rx_err));

  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      rx_buf[rx_cnt % 8] = rx_data;
      rx_cnt = rx_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic m, input logic lp);
    @(negedge clk);
    rst_n = 1'b0; mode = m; loop = lp; limit = '0;
    man_ack = 1'b0; man_dv = 1'b0; tx_valid = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(3);
  endtask

  task automatic push(input logic [DW-1:0] w);
    for (int i = 0; i < 200 && tx_ready !== 1'b1; i++) @(negedge clk);
    tx_valid = 1'b1; tx_data = w;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic wait_dv(input logic lvl);
    for (int i = 0; i < 50 && tx_dv !== lvl; i++) @(negedge clk);
  endtask

  task automatic wait_rx_ack(input logic lvl);
    for (int i = 0; i < 50 && rx_ack !== lvl; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    do_reset(1'b0, 1'b0);
    chk(tx_dv == 1'b0 && rx_ack == 1'b0, "R1 link outputs low", {tx_dv, rx_ack}, 0);
    chk(tx_ready == 1'b1, "R1 sender ready", tx_ready, 1);
    chk(rx_valid == 1'b0 && tx_err == 1'b0 && rx_err == 1'b0, "R1 flags clear",
        {rx_valid, tx_err, rx_err}, 0);
  endtask

  task automatic t_loop(input logic m);
    int base;
    logic [DW-1:0] w [0:2];
    do_reset(m, 1'b1);
    limit = 8'd40;
    if (m) chk(rx_ack == 1'b1, "R5 ready at rest", rx_ack, 1);
    w[0] = 12'hA5C; w[1] = 12'h3E1; w[2] = {11'h0, m};
    base = rx_cnt;
    for (int k = 0; k < 3; k++) push(w[k]);
    for (int i = 0; i < 200 && rx_cnt < base + 3; i++) @(negedge clk);
    chk(rx_cnt == base + 3, m ? "R3 R5 words received" : "R2 R4 words received", rx_cnt - base, 3);
    for (int k = 0; k < 3; k++)
      chk(rx_buf[(base + k) % 8] == w[k], m ? "R3 R5 word value" : "R2 R4 word value",
          rx_buf[(base + k) % 8], w[k]);
    chk(tx_err == 1'b0 && rx_err == 1'b0, "R7 no timeout on live peer", {tx_err, rx_err}, 0);
  endtask

  task automatic t_src_tx_manual;
    do_reset(1'b0, 1'b0);
    push(12'h5A5);
    wait_dv(1'b1);
    chk(tx_dv == 1'b1, "R2 valid raised", tx_dv, 1);
    chk(tx_lnk_data == 12'h5A5, "R6 data with valid", tx_lnk_data, 12'h5A5);
    tick(20);
    chk(tx_dv == 1'b1, "R2 valid held for slow peer", tx_dv, 1);
    man_ack = 1'b1;
    tick(2);
    chk(tx_dv == 1'b1, "R10 valid held two edges after ack", tx_dv, 1);
    tick(1);
    chk(tx_dv == 1'b0, "R10 valid falls on third edge", tx_dv, 0);
    chk(tx_lnk_data == 12'h5A5, "R6 data after valid falls", tx_lnk_data, 12'h5A5);
    tick(10);
    chk(tx_ready == 1'b0, "R2 not ready until ack low", tx_ready, 0);
    man_ack = 1'b0;
    for (int i = 0; i < 20 && tx_ready !== 1'b1; i++) @(negedge clk);
    chk(tx_ready == 1'b1, "R2 ready after ack low", tx_ready, 1);
  endtask

  task automatic t_dst_tx_manual;
    do_reset(1'b1, 1'b0);
    push(12'h1C3);
    tick(20);
    chk(tx_dv == 1'b0, "R3 valid waits for ready", tx_dv, 0);
    man_ack = 1'b1;
    wait_dv(1'b1);
    chk(tx_dv == 1'b1 && tx_lnk_data == 12'h1C3, "R3 valid after ready",
        {tx_dv, tx_lnk_data}, {1'b1, 12'h1C3});
    tick(10);
    chk(tx_dv == 1'b1, "R3 valid held while ready high", tx_dv, 1);
    man_ack = 1'b0;
    wait_dv(1'b0);
    chk(tx_dv == 1'b0, "R3 valid drops after ready drops", tx_dv, 0);
    chk(tx_lnk_data == 12'h1C3, "R6 data held after drop", tx_lnk_data, 12'h1C3);
  endtask

  task automatic t_rx_src_manual;
    int base;
    do_reset(1'b0, 1'b0);
    base = rx_cnt;
    man_data = 12'h7B2;
    tick(1);
    man_dv = 1'b1;
    wait_rx_ack(1'b1);
    tick(1);
    chk(rx_cnt == base + 1 && rx_buf[base % 8] == 12'h7B2, "R4 capture on valid",
        rx_buf[base % 8], 12'h7B2);
    tick(10);
    chk(rx_ack == 1'b1 && rx_cnt == base + 1, "R4 ack held, single capture",
        rx_cnt - base, 1);
    man_dv = 1'b0;
    wait_rx_ack(1'b0);
    chk(rx_ack == 1'b0, "R4 ack drops after valid low", rx_ack, 0);
  endtask

  task automatic t_rx_dst_manual;
    int base;
    do_reset(1'b1, 1'b0);
    chk(rx_ack == 1'b1, "R5 ready at rest", rx_ack, 1);
    base = rx_cnt;
    man_data = 12'h0F4;
    tick(1);
    man_dv = 1'b1;
    wait_rx_ack(1'b0);
    tick(1);
    chk(rx_cnt == base + 1 && rx_buf[base % 8] == 12'h0F4, "R5 capture drops ready",
        rx_buf[base % 8], 12'h0F4);
    tick(10);
    chk(rx_ack == 1'b0, "R5 ready stays low while valid high", rx_ack, 0);
    man_dv = 1'b0;
    wait_rx_ack(1'b1);
    chk(rx_ack == 1'b1 && rx_cnt == base + 1, "R5 ready back, one capture", rx_cnt - base, 1);
  endtask

  task automatic t_tx_timeout;
    do_reset(1'b0, 1'b0);
    limit = 8'd16;
    push(12'h222);
    wait_dv(1'b1);
    tick(8);
    chk(tx_err == 1'b0, "R7 no error before limit", tx_err, 0);
    tick(20);
    chk(tx_err == 1'b1, "R7 sender error set", tx_err, 1);
    chk(tx_dv == 1'b0 && tx_ready == 1'b1, "R7 sender back to idle", {tx_dv, tx_ready}, 2'b01);
    man_ack = 1'b1;
    tick(10);
    chk(tx_err == 1'b1, "R7 sender error sticky", tx_err, 1);
  endtask

  task automatic t_rx_timeout;
    int base;
    do_reset(1'b0, 1'b0);
    limit = 8'd16;
    base = rx_cnt;
    man_data = 12'h999;
    man_dv = 1'b1;
    wait_rx_ack(1'b1);
    tick(30);
    chk(rx_err == 1'b1 && rx_ack == 1'b0, "R7 receiver error and ack low",
        {rx_err, rx_ack}, 2'b10);
    chk(rx_cnt == base + 1, "R7 no recapture after timeout", rx_cnt - base, 1);
  endtask

  task automatic t_no_timeout;
    do_reset(1'b0, 1'b0);
    limit = '0;
    push(12'h444);
    wait_dv(1'b1);
    tick(200);
    chk(tx_dv == 1'b1 && tx_err == 1'b0, "R8 waits indefinitely", {tx_dv, tx_err}, 2'b10);
    man_ack = 1'b1;
    wait_dv(1'b0);
    man_ack = 1'b0;
    tick(6);
    chk(tx_ready == 1'b1 && tx_err == 1'b0, "R8 completes late", {tx_ready, tx_err}, 2'b10);
  endtask

  task automatic t_mode_change;
    do_reset(1'b0, 1'b0);
    push(12'h6D6);
    wait_dv(1'b1);
    mode = 1'b1;
    tick(2);
    chk(rx_ack == 1'b0, "R9 receiver keeps old mode mid-transfer", rx_ack, 0);
    man_ack = 1'b1;
    tick(3);
    chk(tx_dv == 1'b0, "R9 sender finishes in old mode", tx_dv, 0);
    man_ack = 1'b0;
    for (int i = 0; i < 20 && tx_ready !== 1'b1; i++) @(negedge clk);
    tick(3);
    chk(rx_ack == 1'b1, "R9 new mode once quiet", rx_ack, 1);
    push(12'h6D7);
    tick(10);
    chk(tx_dv == 1'b0, "R9 sender now waits for ready", tx_dv, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_loop(1'b0);
    t_loop(1'b1);
    t_src_tx_manual();
    t_dst_tx_manual();
    t_rx_src_manual();
    t_rx_dst_manual();
    t_tx_timeout();
    t_rx_timeout();
    t_no_timeout();
    t_mode_change();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule